// File: doc/BRIEF.md
# Add-Subtract ALU with Overflow

This block is a combinational arithmetic and logic unit of parameterised width. Its add path is a ripple chain of one-bit full-adder slices. The same chain also subtracts: a subtract control inverts every bit of the second operand and feeds a carry of one into the least significant slice, so no second adder is needed. A two-bit operation select picks the result from one of three paths:

- the add/subtract path,
- a bitwise AND of the operands,
- a bitwise inversion of the first operand.

Beside the result the block reports the carry leaving the top slice and a signed (two's-complement) overflow flag. The flag is derived only from the sign bits of the first operand, of the effective second operand (after any inversion) and of the sum. Nothing in the block holds state. The block is meant to sit inside a datapath that registers its inputs and outputs elsewhere.

Top module: `addsub_alu`

## Requirements
- R1: With op_sel_i = 2'b00 and sub_en_i = 0, res_o equals (opd_a_i + opd_b_i) mod 2^W, and carry_o equals bit W of the unsigned (W+1)-bit sum.
- R2: With op_sel_i = 2'b00 and sub_en_i = 1, res_o equals (opd_a_i + ~opd_b_i + 1) mod 2^W, and carry_o equals bit W of that unsigned sum. carry_o is 1 exactly when opd_a_i >= opd_b_i as unsigned numbers.
- R3: For op_sel_i = 2'b00, ovf_o is 1 exactly when the true signed sum (or the true signed difference when sub_en_i = 1) lies outside [-2^(W-1), 2^(W-1)-1]. ovf_o is never 1 when the first operand and the effective second operand differ in their top bit.
- R4: With op_sel_i = 2'b01, res_o equals opd_a_i & opd_b_i, and carry_o and ovf_o are 0.
- R5: With op_sel_i = 2'b10, res_o equals ~opd_a_i, and carry_o and ovf_o are 0. opd_b_i has no effect on any output.
- R6: With op_sel_i = 2'b11, res_o is all zeros, and carry_o and ovf_o are 0.
- R7: For op_sel_i other than 2'b00, sub_en_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a_i | input | W | First operand (X) |
| opd_b_i | input | W | Second operand (Y) |
| op_sel_i | input | 2 | Operation: 00 add/sub, 01 AND, 10 invert A, 11 unused |
| sub_en_i | input | 1 | 1 turns the add path into A minus B |
| res_o | output | W | Result Z |
| carry_o | output | 1 | Carry out of the most significant slice (add path only) |
| ovf_o | output | 1 | Signed overflow (add path only) |

## Verification
All three results are pure combinational functions of the current inputs. Each output is therefore due in the same cycle that the inputs change, after the ripple chain settles, with no register on the way. The bench changes inputs on the falling edge of its own clock. It samples res_o, carry_o and ovf_o a fixed 1 ns later, well before the next rising edge, so every comparison sees settled values. No result is read across a cycle boundary.

// File: rtl/addsub_alu_pkg.sv
// Package: shared operation codes for the add/subtract ALU.
// Assumes: a two-bit select; the code values are fixed by the datapath decode.
package addsub_alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_AND  = 2'b01,
        OP_NOT  = 2'b10,
        OP_NONE = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_bit_slice.sv
// Module: one-bit full adder slice.
// Does: sum = cin ^ a ^ b; cout = a&b | cin&(a^b).
// Assumes: used inside a ripple chain; no state.
module alu_bit_slice (
    input  logic a_i,
    input  logic b_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    logic half_x;

    // Partial sum shared by sum and carry terms.
    assign half_x = a_i ^ b_i;
    // Sum bit of the slice.
    assign sum_o  = cin_i ^ half_x;
    // Carry: generated by a&b or passed on when exactly one input is set.
    assign cout_o = (a_i & b_i) | (cin_i & half_x);
endmodule

// File: rtl/alu_ripple_adder.sv
// Module: W-bit ripple adder/subtractor built from alu_bit_slice.
// Does: b is XORed with sub_i per bit, and sub_i is the chain carry-in,
//       giving a + b or a + ~b + 1 with one chain.
// Assumes: W >= 2; purely combinational.
module alu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] b_eff_o,
    output logic         cout_o
);
    localparam int CW = W + 1;

    logic [W:0] chain;

    // Carry-in of bit 0 is the subtract control.
    assign chain[0] = sub_i;

    for (genvar i = 0; i < W; i++) begin : g_slice
        // Conditional inversion of the second operand for this bit.
        assign b_eff_o[i] = b_i[i] ^ sub_i;
        alu_bit_slice u_slice (
            .a_i   (a_i[i]),
            .b_i   (b_eff_o[i]),
            .cin_i (chain[i]),
            .sum_o (sum_o[i]),
            .cout_o(chain[i+1])
        );
    end

    // Carry leaving the top slice.
    assign cout_o = chain[W];

    // Chain result must match a whole-word addition of the same operands.
    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            p_chain_sum_r1: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_eff_o} + CW'(sub_i)))
                else $error("ripple chain disagrees with word sum");
        end
    end
endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise paths of the ALU.
// Does: AND of both operands, and inversion of the first operand only.
// Assumes: combinational; the second operand never reaches the invert path.
module alu_logic_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] inv_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit AND and inversion.
        assign and_o[i] = a_i[i] & b_i[i];
        assign inv_o[i] = ~a_i[i];
    end
endmodule

// File: rtl/alu_ovf_detect.sv
// Module: signed overflow from the three sign bits.
// Does: flags overflow when both operand signs agree and the sum sign differs.
// Assumes: sb_i is the effective (possibly inverted) second operand sign.
module alu_ovf_detect (
    input  logic sa_i,
    input  logic sb_i,
    input  logic sz_i,
    output logic ovf_o
);
    // Two positives giving a negative, or two negatives giving a positive.
    assign ovf_o = (sa_i & sb_i & ~sz_i) | (~sa_i & ~sb_i & sz_i);
endmodule

// File: rtl/addsub_alu.sv
// Module: top of the add/subtract ALU.
// Does: selects the add/sub, AND or invert path by op_sel_i; code 11 gives 0.
//       Carry and overflow are only reported for the add path.
// Assumes: W >= 2; combinational; caller registers around it.
module addsub_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] opd_a_i,
    input  logic [W-1:0] opd_b_i,
    input  logic [1:0]   op_sel_i,
    input  logic         sub_en_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);
    import addsub_alu_pkg::*;

    localparam int MSB = W - 1;

    alu_op_e     op;
    logic [W-1:0] sum_w, b_eff_w, and_w, inv_w;
    logic         cout_w, ovf_w;

    // Decode the select into the named operation.
    assign op = alu_op_e'(op_sel_i);

    alu_ripple_adder #(.W(W)) u_adder (
        .a_i    (opd_a_i),
        .b_i    (opd_b_i),
        .sub_i  (sub_en_i),
        .sum_o  (sum_w),
        .b_eff_o(b_eff_w),
        .cout_o (cout_w)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a_i  (opd_a_i),
        .b_i  (opd_b_i),
        .and_o(and_w),
        .inv_o(inv_w)
    );

    alu_ovf_detect u_ovf (
        .sa_i (opd_a_i[MSB]),
        .sb_i (b_eff_w[MSB]),
        .sz_i (sum_w[MSB]),
        .ovf_o(ovf_w)
    );

    // Output select; flags are cleared outside the add path.
    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        case (op)
            OP_ADD: begin
                res_o   = sum_w;
                carry_o = cout_w;
                ovf_o   = ovf_w;
            end
            OP_AND:  res_o = and_w;
            OP_NOT:  res_o = inv_w;
            default: res_o = '0;
        endcase
    end

    // Checks on the settled outputs against the separately driven paths.
    always_comb begin
        if (!$isunknown({opd_a_i, opd_b_i, op_sel_i, sub_en_i})) begin
            p_no_overflow_r3: assert (!(opd_a_i[MSB] != b_eff_w[MSB] && ovf_o))
                else $error("overflow raised for operands of opposite sign");
            p_flags_clear_r4: assert (op_sel_i == 2'b00 || (!carry_o && !ovf_o))
                else $error("flags set outside add path");
            p_invert_r5: assert (op_sel_i != 2'b10 || res_o == ~opd_a_i)
                else $error("invert path result wrong");
            p_unused_zero_r6: assert (op_sel_i != 2'b11 || res_o == '0)
                else $error("unused code gave nonzero result");
            p_add_result_r1: assert (op_sel_i != 2'b00 || res_o == sum_w)
                else $error("add path not selected");
        end
    end
endmodule

// File: tb/addsub_alu_tb_top.sv
module addsub_alu_tb_top;
    localparam int W = 8;
    localparam int MAXV = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic [1:0]   op;
    logic         sub;
    logic [W-1:0] res;
    logic         cy, ov;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    addsub_alu #(.W(W)) dut_i (
        .opd_a_i (a), .opd_b_i (b), .op_sel_i(op), .sub_en_i(sub),
        .res_o   (res), .carry_o (cy), .ovf_o  (ov)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h (a=%0h b=%0h op=%0d sub=%0b)",
                     req, got, exp, a, b, op, sub);
        end
    endtask

    // Drive on the falling edge; results are due 1 ns later, same cycle.
    task automatic apply(input int ia, input int ib, input int iop, input bit isub);
        @(negedge clk);
        a = W'(ia); b = W'(ib); op = 2'(iop); sub = isub;
        #1;
    endtask

    // Behavioural reference for the add path: value, carry, overflow.
    task automatic ref_add(input int ia, input int ib, input bit isub,
                           output int z, output int c, output int v);
        int sa, sb, full, s;
        if (isub) full = ia + ((MAXV - 1) - ib) + 1;
        else      full = ia + ib;
        z = full % MAXV;
        c = (full >= MAXV) ? 1 : 0;
        sa = (ia >= MAXV/2) ? ia - MAXV : ia;
        sb = (ib >= MAXV/2) ? ib - MAXV : ib;
        s = isub ? sa - sb : sa + sb;
        v = (s < -(MAXV/2) || s > MAXV/2 - 1) ? 1 : 0;
    endtask

    task automatic check_add(input string req, input int ia, input int ib, input bit isub);
        int z, c, v;
        apply(ia, ib, 0, isub);
        ref_add(ia, ib, isub, z, c, v);
        chk(req, res, z);
        chk(req, cy, c);
        chk("R3", ov, v);
    endtask

    task automatic t_idle;
        apply(0, 0, 0, 0);
        chk("R1 idle res", res, 0);
        chk("R1 idle carry", cy, 0);
        chk("R3 idle ovf", ov, 0);
    endtask

    // R1: plain addition, corners and sweep.
    task automatic t_add;
        check_add("R1", 8'hFF, 8'h01, 0);
        check_add("R1", 8'h7F, 8'h01, 0);
        check_add("R1", 8'h80, 8'h80, 0);
        check_add("R1", 8'h55, 8'hAA, 0);
        for (int i = 0; i < 2000; i++) check_add("R1", $urandom % MAXV, $urandom % MAXV, 0);
    endtask

    // R2: subtraction via inversion and carry-in.
    task automatic t_sub;
        check_add("R2", 5, 5, 1);
        check_add("R2", 3, 5, 1);
        check_add("R2", 0, 0, 1);
        check_add("R2", 8'h00, 8'h80, 1);
        check_add("R2", 8'h80, 8'h01, 1);
        for (int i = 0; i < 2000; i++) check_add("R2", $urandom % MAXV, $urandom % MAXV, 1);
        apply(10, 200, 0, 1);
        chk("R2 borrow carry", cy, 0);
        apply(200, 10, 0, 1);
        chk("R2 no-borrow carry", cy, 1);
    endtask

    // R3: opposite effective signs never overflow, exhaustive on the sign rule.
    task automatic t_ovf;
        apply(8'h7F, 8'h80, 0, 0);
        chk("R3 opposite signs", ov, 0);
        apply(8'h80, 8'hFF, 0, 0);
        chk("R3 neg+neg wrap", ov, 1);
        apply(8'h40, 8'h40, 0, 0);
        chk("R3 pos+pos wrap", ov, 1);
        for (int ia = 0; ia < MAXV; ia += 7)
            for (int ib = 0; ib < MAXV; ib += 5) begin
                check_add("R1", ia, ib, 0);
                check_add("R2", ia, ib, 1);
            end
    endtask

    // R4: AND with cleared flags.
    task automatic t_and;
        for (int i = 0; i < 300; i++) begin
            int ia = $urandom % MAXV;
            int ib = $urandom % MAXV;
            apply(ia, ib, 1, 0);
            chk("R4 and", res, ia & ib);
            chk("R4 carry", cy, 0);
            chk("R4 ovf", ov, 0);
        end
    endtask

    // R5: invert A; B has no effect.
    task automatic t_not;
        for (int i = 0; i < 300; i++) begin
            int ia = $urandom % MAXV;
            apply(ia, $urandom % MAXV, 2, 0);
            chk("R5 not", res, (~ia) & (MAXV - 1));
            chk("R5 carry", cy, 0);
            chk("R5 ovf", ov, 0);
        end
        apply(8'h0F, 8'h00, 2, 0);
        chk("R5 b=00", res, 8'hF0);
        apply(8'h0F, 8'hFF, 2, 0);
        chk("R5 b=FF ignored", res, 8'hF0);
    endtask

    // R6: unused code yields zeros.
    task automatic t_unused;
        apply(8'hFF, 8'hFF, 3, 0);
        chk("R6 res", res, 0);
        chk("R6 carry", cy, 0);
        chk("R6 ovf", ov, 0);
        apply(8'h7F, 8'h7F, 3, 1);
        chk("R6 res sub", res, 0);
    endtask

    // R7: sub_en_i ignored outside the add path.
    task automatic t_sub_ignored;
        for (int o = 1; o < 4; o++) begin
            int r0, c0, v0;
            apply(8'hC3, 8'h5A, o, 0);
            r0 = res; c0 = cy; v0 = ov;
            apply(8'hC3, 8'h5A, o, 1);
            chk("R7 res", res, r0);
            chk("R7 carry", cy, c0);
            chk("R7 ovf", ov, v0);
        end
    endtask

    initial begin
        a = '0; b = '0; op = '0; sub = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle;
        t_add;
        t_sub;
        t_ovf;
        t_and;
        t_not;
        t_unused;
        t_sub_ignored;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule